// File: doc/BRIEF.md
# Shared Timer Control Register Block

This block holds the configuration of a bank of eight timer channels in one shared 32-bit control word. Each timer owns a 4-bit slot in that word. The block decodes a small window of a simple register bus and drives the settled control vectors that the timer channels consume.

Bulk clearing of control bits goes through a dedicated register. In the default register map, that clear is guarded by a lock. Software opens and closes the lock by writing command bytes, and it can read the lock state back.

A mode input selects a second register map. In that map, one offset exposes per-timer interrupt status that software clears by writing ones, and the bulk clear works without the lock.

Between the control word and the timer channels sits a per-timer sequencer. When a timer is switched on, its configuration reaches the channel before the enable does. When a timer is switched off, the enable drops before any configuration moves. The pulse option is only passed on to the upper timers. On the lower timers the bit is stored but raises an unsupported flag instead.

Top module: `gtimer_ctl`

## Requirements
- R1: Offset 0x30 reads and writes the whole control word. Timer n uses bits [4n+3:4n], with enable at bit 4n, clock select at 4n+1, overflow interrupt enable at 4n+2 and pulse enable at 4n+3.
- R2: A write to offset 0x38 in map 0 carries a command byte in write-data bits [8:1]. 0xAE opens the lock, 0xEA closes it, and any other byte leaves the lock unchanged. Reading 0x38 in map 0 returns the lock in bit 0 (1 = open) and zeros elsewhere.
- R3: In map 0, a write to offset 0x3C clears every control bit whose data bit is 1, but only while the lock is open. While the lock is closed, the write changes nothing.
- R4: When a timer's enable goes from 0 to 1 together with a configuration change, its configuration outputs update one cycle after the write and its enable output one cycle after that. With no configuration change, the enable output rises one cycle after the write.
- R5: When a timer's enable goes from 1 to 0, its enable output falls one cycle after the write, and any configuration change reaches the outputs one cycle later.
- R6: A configuration change on a timer whose enable stays 1 reaches its outputs one cycle after the write, and its enable output stays 1 throughout.
- R7: The pulse output is driven only for timers 4 to 7. For timers 0 to 3 the pulse bit is stored and read back, the pulse output stays 0, and the unsupported flag for that timer follows the applied pulse bit.
- R8: In map 1, offset 0x34 reads the interrupt status with bit n for timer n. An event input pulse sets the bit. Writing 1 clears it. An event and a clear of the same bit in one cycle leave the bit set.
- R9: In map 1, a write to 0x3C clears control bits whatever the lock state. Offset 0x38 reads 0, and writes to it do not change the lock.
- R10: After reset, the control word, the interrupt status and all timer outputs are 0, and the lock is closed.
- R11: In map 0, offset 0x34 reads 0, and writes to it leave the interrupt status unchanged.
- R12: Read data appears on the cycle after the read strobe. Offsets outside 0x30, 0x34, 0x38 and 0x3C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| map_sel | input | 1 | 0: locked-clear map, 1: interrupt-status map |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_evt | input | 8 | Per-timer interrupt event pulses |
| tmr_en | output | 8 | Applied enable per timer |
| tmr_extclk | output | 8 | Applied clock select per timer |
| tmr_ovf_ie | output | 8 | Applied overflow interrupt enable per timer |
| tmr_pulse | output | 8 | Applied pulse enable, upper timers only |
| pulse_unsup | output | 8 | Pulse requested on a timer without pulse support |

## Verification
Several properties are checked on every cycle. The sequencer never moves an enable and a configuration in the same cycle. A closed lock or an unknown command byte leaves the lock and the control word untouched. A cleared status bit with no new event reads 0 afterwards.

Other behaviours are shown only by the bench scenarios. These are the exact cycle on which each output settles after a write, the set-wins collision on the status register, and read-back through both maps, including the evidence that ignored writes really changed nothing.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  localparam int SLOT_W = 4;
  localparam int CFG_W  = 3;

  // field position inside one timer slot
  localparam int FLD_EN    = 0;
  localparam int FLD_EXT   = 1;
  localparam int FLD_OVF   = 2;
  localparam int FLD_PULSE = 3;

  // register offsets
  localparam int OFS_CTRL = 'h30;
  localparam int OFS_AUX  = 'h34;
  localparam int OFS_LOCK = 'h38;
  localparam int OFS_CLR  = 'h3C;

  typedef enum logic [7:0] {
    CMD_OPEN  = 8'hAE,
    CMD_CLOSE = 8'hEA
  } lock_cmd_e;

  typedef struct packed {
    logic pulse;
    logic ovf;
    logic ext;
  } tmr_cfg_t;
endpackage

// File: rtl/gtc_lock.sv
module gtc_lock
  import gtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd,
  output logic       open_o
);
  logic open_q;
  logic open_d;
  logic open_ce;

  always_comb begin
    open_d = open_q;
    if (cmd_wr) begin
      if (cmd == CMD_OPEN)       open_d = 1'b1;
      else if (cmd == CMD_CLOSE) open_d = 1'b0;
    end
  end

  assign open_ce = cmd_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (open_ce) open_q <= open_d;
  end

  assign open_o = open_q;

  AST_LOCK_OTHER_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd != CMD_OPEN && cmd != CMD_CLOSE) |=> $stable(open_q)); // R2
  AST_LOCK_OPEN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd == CMD_OPEN) |=> open_q); // R2
endmodule

// File: rtl/gtc_regs.sv
module gtc_regs
  import gtc_pkg::*;
#(
  parameter int NT = 8,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 map_sel,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NT-1:0]        irq_evt,
  input  logic                 lock_open,
  output logic                 lock_cmd_wr,
  output logic [7:0]           lock_cmd,
  output logic [NT*SLOT_W-1:0] ctrl_o,
  output logic [DW-1:0]        rdata
);
  localparam int CW = NT * SLOT_W;

  logic hit_ctrl;
  logic hit_aux;
  logic hit_lock;
  logic hit_clr;

  logic wr_ctrl;
  logic wr_clr;
  logic wr_sts;

  logic [CW-1:0] ctrl_q;
  logic [CW-1:0] ctrl_d;
  logic          ctrl_ce;

  logic [NT-1:0] sts_q;
  logic [NT-1:0] sts_d;
  logic          sts_ce;

  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;

  assign hit_ctrl = (addr == AW'(OFS_CTRL));
  assign hit_aux  = (addr == AW'(OFS_AUX));
  assign hit_lock = (addr == AW'(OFS_LOCK));
  assign hit_clr  = (addr == AW'(OFS_CLR));

  assign wr_ctrl     = wr && hit_ctrl;
  assign wr_clr      = wr && hit_clr && (map_sel || lock_open);
  assign wr_sts      = wr && hit_aux && map_sel;
  assign lock_cmd_wr = wr && hit_lock && !map_sel;
  assign lock_cmd    = wdata[8:1];

  // control word next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)     ctrl_d = wdata[CW-1:0];
    else if (wr_clr) ctrl_d = ctrl_q & ~wdata[CW-1:0];
  end

  assign ctrl_ce = wr_ctrl || wr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  // interrupt status: events win over a same-cycle clear
  always_comb begin
    sts_d = sts_q;
    if (wr_sts) sts_d = sts_d & ~wdata[NT-1:0];
    sts_d = sts_d | irq_evt;
  end

  assign sts_ce = wr_sts || (|irq_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  // read path, registered
  always_comb begin
    rdata_d = '0;
    if (hit_ctrl)                 rdata_d[CW-1:0] = ctrl_q;
    else if (hit_aux && map_sel)  rdata_d[NT-1:0] = sts_q;
    else if (hit_lock && !map_sel) rdata_d[0]     = lock_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata  = rdata_q;
  assign ctrl_o = ctrl_q;

  AST_CLOSED_CLEAR_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_clr && !map_sel && !lock_open) |=> $stable(ctrl_q)); // R3
  AST_STS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_aux && map_sel && wdata[0] && !irq_evt[0]) |=> !sts_q[0]); // R8
  AST_MAP0_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_sel && !(|irq_evt)) |=> $stable(sts_q)); // R11
endmodule

// File: rtl/gtc_seq.sv
module gtc_seq
  import gtc_pkg::*;
#(
  parameter int IDX         = 0,
  parameter int FIRST_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] req,
  output logic              en_o,
  output logic              ext_o,
  output logic              ovf_o,
  output logic              pulse_o,
  output logic              unsup_o
);
  tmr_cfg_t req_cfg;
  tmr_cfg_t cfg_q;
  tmr_cfg_t cfg_d;
  logic     req_en;
  logic     en_q;
  logic     en_d;
  logic     step_ce;

  assign req_en        = req[FLD_EN];
  assign req_cfg.ext   = req[FLD_EXT];
  assign req_cfg.ovf   = req[FLD_OVF];
  assign req_cfg.pulse = req[FLD_PULSE];

  // one step per cycle: disable first, then configuration, then enable
  always_comb begin
    en_d  = en_q;
    cfg_d = cfg_q;
    if (en_q && !req_en)         en_d  = 1'b0;
    else if (cfg_q != req_cfg)   cfg_d = req_cfg;
    else if (!en_q && req_en)    en_d  = 1'b1;
  end

  assign step_ce = (en_d != en_q) || (cfg_d != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
    end else if (step_ce) begin
      en_q  <= en_d;
      cfg_q <= cfg_d;
    end
  end

  assign en_o  = en_q;
  assign ext_o = cfg_q.ext;
  assign ovf_o = cfg_q.ovf;

  generate
    if (IDX >= FIRST_PULSE) begin : g_pulse
      assign pulse_o = cfg_q.pulse;
      assign unsup_o = 1'b0;
    end else begin : g_nopulse
      assign pulse_o = 1'b0;
      assign unsup_o = cfg_q.pulse;
    end
  endgenerate

  AST_EN_RISE_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $stable(cfg_q)); // R4
  AST_EN_FALL_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $stable(cfg_q)); // R5
  AST_CFG_MOVE_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $stable(en_q)); // R6
endmodule

// File: rtl/gtimer_ctl.sv
module gtimer_ctl
  import gtc_pkg::*;
#(
  parameter int NT          = 8,
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int FIRST_PULSE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NT-1:0] irq_evt,
  output logic [NT-1:0] tmr_en,
  output logic [NT-1:0] tmr_extclk,
  output logic [NT-1:0] tmr_ovf_ie,
  output logic [NT-1:0] tmr_pulse,
  output logic [NT-1:0] pulse_unsup
);
  localparam int CW = NT * SLOT_W;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          lock_open;
  logic          lock_cmd_wr;
  logic [7:0]    lock_cmd;
  logic [CW-1:0] ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[1];

  gtc_regs #(.NT(NT), .AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .map_sel     (map_sel),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .irq_evt     (irq_evt),
    .lock_open   (lock_open),
    .lock_cmd_wr (lock_cmd_wr),
    .lock_cmd    (lock_cmd),
    .ctrl_o      (ctrl),
    .rdata       (bus_rdata)
  );

  gtc_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cmd_wr (lock_cmd_wr),
    .cmd    (lock_cmd),
    .open_o (lock_open)
  );

  generate
    for (genvar i = 0; i < NT; i++) begin : g_tmr
      gtc_seq #(.IDX(i), .FIRST_PULSE(FIRST_PULSE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .req     (ctrl[i*SLOT_W +: SLOT_W]),
        .en_o    (tmr_en[i]),
        .ext_o   (tmr_extclk[i]),
        .ovf_o   (tmr_ovf_ie[i]),
        .pulse_o (tmr_pulse[i]),
        .unsup_o (pulse_unsup[i])
      );
    end
  endgenerate

  AST_RESET_OUTPUTS_LOW: assert property (@(posedge clk)
    (!rst_core_n) |-> (tmr_en == '0 && lock_open == 1'b0)); // R10
endmodule

// File: tb/gtimer_ctl_tb.sv
module gtimer_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_evt = '0;
  logic [7:0]  tmr_en, tmr_extclk, tmr_ovf_ie, tmr_pulse, pulse_unsup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gtimer_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_evt(irq_evt),
    .tmr_en(tmr_en), .tmr_extclk(tmr_extclk), .tmr_ovf_ie(tmr_ovf_ie),
    .tmr_pulse(tmr_pulse), .pulse_unsup(pulse_unsup)
  );

  // vector: {map, is_read, addr[7:0], data[31:0], expect[31:0]}
  localparam int NV = 22;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h30, 32'h8421_1248, 32'h0},           // R1 write word
    {1'b0, 1'b1, 8'h30, 32'h0,         32'h8421_1248},   // R1 read back
    {1'b0, 1'b1, 8'h38, 32'h0,         32'h0},           // R2 closed after reset
    {1'b0, 1'b0, 8'h3C, 32'hFFFF_FFFF, 32'h0},           // R3 clear while closed
    {1'b0, 1'b1, 8'h30, 32'h0,         32'h8421_1248},   // R3 unchanged
    {1'b0, 1'b0, 8'h38, 32'h0000_00AA, 32'h0},           // R2 other byte 0x55
    {1'b0, 1'b1, 8'h38, 32'h0,         32'h0},           // R2 still closed
    {1'b0, 1'b0, 8'h38, 32'h0000_015C, 32'h0},           // R2 open
    {1'b0, 1'b1, 8'h38, 32'h0,         32'h1},           // R2 reads open
    {1'b0, 1'b0, 8'h3C, 32'h0000_00F0, 32'h0},           // R3 clear timer1 slot
    {1'b0, 1'b1, 8'h30, 32'h0,         32'h8421_1208},   // R3 cleared
    {1'b0, 1'b0, 8'h38, 32'h0000_0066, 32'h0},           // R2 other byte 0x33
    {1'b0, 1'b1, 8'h38, 32'h0,         32'h1},           // R2 still open
    {1'b0, 1'b0, 8'h38, 32'h0000_01D4, 32'h0},           // R2 close
    {1'b0, 1'b1, 8'h38, 32'h0,         32'h0},           // R2 reads closed
    {1'b0, 1'b1, 8'h34, 32'h0,         32'h0},           // R11 map 0 aux reads 0
    {1'b0, 1'b1, 8'h20, 32'h0,         32'h0},           // R12 unmapped
    {1'b1, 1'b1, 8'h38, 32'h0,         32'h0},           // R9 map 1 lock reads 0
    {1'b1, 1'b0, 8'h38, 32'h0000_015C, 32'h0},           // R9 open ignored
    {1'b1, 1'b0, 8'h3C, 32'h0000_0008, 32'h0},           // R9 clear while closed
    {1'b1, 1'b1, 8'h30, 32'h0,         32'h8421_1200},   // R9 cleared anyway
    {1'b0, 1'b1, 8'h38, 32'h0,         32'h0}            // R9 lock unchanged
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    logic [73:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk({24'h0, tmr_en | tmr_extclk | tmr_ovf_ie | tmr_pulse | pulse_unsup}, 32'h0, "R10 outputs");
    rd_chk(8'h30, 32'h0, "R10 control word");
    rd_chk(8'h38, 32'h0, "R10 lock closed");
    map_sel = 1'b1;
    rd_chk(8'h34, 32'h0, "R10 status");
    map_sel = 1'b0;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      map_sel = v[73];
      if (v[72]) rd_chk(v[71:64], v[31:0], $sformatf("table vector %0d", i));
      else       wr(v[71:64], v[63:32]);
    end
    map_sel = 1'b0;

    wr(8'h30, 32'h0);
    repeat (3) @(negedge clk);

    // R4 enable with configuration: cfg first, enable next cycle
    wr(8'h30, 32'h7);
    chk({29'h0, tmr_en[0], tmr_ovf_ie[0], tmr_extclk[0]}, 32'h0, "R4 write cycle");
    @(negedge clk);
    chk({29'h0, tmr_en[0], tmr_ovf_ie[0], tmr_extclk[0]}, 32'h3, "R4 cfg applied");
    @(negedge clk);
    chk({29'h0, tmr_en[0], tmr_ovf_ie[0], tmr_extclk[0]}, 32'h7, "R4 enabled");

    // R6 config change while enabled
    wr(8'h30, 32'h5);
    @(negedge clk);
    chk({29'h0, tmr_en[0], tmr_ovf_ie[0], tmr_extclk[0]}, 32'h6, "R6 cfg while on");

    // R5 disable first, then config
    wr(8'h30, 32'h0);
    @(negedge clk);
    chk({29'h0, tmr_en[0], tmr_ovf_ie[0], tmr_extclk[0]}, 32'h2, "R5 enable dropped");
    @(negedge clk);
    chk({29'h0, tmr_en[0], tmr_ovf_ie[0], tmr_extclk[0]}, 32'h0, "R5 cfg cleared");

    // R4 enable alone
    wr(8'h30, 32'h1);
    @(negedge clk);
    chk({31'h0, tmr_en[0]}, 32'h1, "R4 enable only");

    // R7 pulse support split
    wr(8'h30, 32'h8000_0008);
    repeat (3) @(negedge clk);
    chk({16'h0, tmr_pulse, pulse_unsup}, 32'h8001, "R7 pulse and unsupported flag");
    rd_chk(8'h30, 32'h8000_0008, "R7 low pulse bit stored");

    // R8 interrupt status in map 1
    map_sel = 1'b1;
    @(negedge clk);
    irq_evt = 8'h05;
    @(negedge clk);
    irq_evt = 8'h00;
    rd_chk(8'h34, 32'h05, "R8 events set");
    wr(8'h34, 32'h01);
    rd_chk(8'h34, 32'h04, "R8 write one clears");
    @(negedge clk);
    irq_evt = 8'h04; bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h04;
    @(negedge clk);
    irq_evt = 8'h00; bus_wr = 1'b0;
    rd_chk(8'h34, 32'h04, "R8 set wins over clear");

    // R11 map 0 write to aux ignored
    map_sel = 1'b0;
    wr(8'h34, 32'hFF);
    map_sel = 1'b1;
    rd_chk(8'h34, 32'h04, "R11 status kept");
    map_sel = 1'b0;

    // R12 read data held until next strobe
    rd_chk(8'h3C, 32'h0, "R12 clear offset reads 0");

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual hung expected done");
      finish_run();
    end
  end
endmodule